// File: doc/BRIEF.md
# Flash Two-Step Command Controller

This block sits on the device side of a byte-wide, sector-erasable flash. It watches host byte writes and turns them into array operations. A destructive operation only runs after a matching pair of writes. First comes a setup opcode, then an execute write. When the execute write is accepted, the block sends a one-cycle request to the array for one of three operations: program one byte, erase one sector, or erase the whole array. It then holds a busy flag for a fixed number of clock cycles, counted by an internal timer.

While the busy flag is high, the block steers reads of the last target address to a status path. On that path the external read mux inverts bit 7 of the array byte and puts `toggleBit` on bit 6. Outside an operation, an identification mode can be entered; in that mode reads return fixed code bytes. A separate detector drives the protection flag `protectOn`, and destructive commands are refused while it is set.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, `busy` is 0, all three requests are 0, `rdSel` is 0 (array), `toggleBit` is 0, and no command is pending.
- R2: Writing 10h and then any byte other than FFh to address A gives `progReq` high for one cycle, starting the cycle after the second write. With it, `reqAddr`=A and `reqData` is that byte. `busy` is then high for PROG_CYC cycles.
- R3: Writing 20h and then D0h to address A gives an `eraseSecReq` pulse. `reqAddr` keeps A's bits above bit 7 and has bits 7..0 forced to zero, so the sector is 256 bytes. `busy` is then high for SEC_CYC cycles.
- R4: Writing 30h and then 30h gives an `eraseAllReq` pulse, and `busy` is then high for ALL_CYC cycles.
- R5: A write of FFh after any setup opcode cancels it: no request is issued, `busy` stays 0, and the next write is treated as a fresh command.
- R6: A sector or chip setup followed by any execute byte other than its matching one (D0h or 30h respectively) drops the sequence without a request.
- R7: While `protectOn` is 1, setup opcodes 10h, 20h and 30h are ignored and no execute write is accepted.
- R8: Writing 90h enters identification mode. There `rdSel`=1 and `idByte` is BFh at address 0, 04h at address 1 and 00h elsewhere. Writing 10h, 20h, 30h or FFh leaves the mode. Entry and exit work while protected.
- R9: While `busy` is 1, every write is ignored, except that FFh ends an erase. FFh does not shorten a program.
- R10: FFh written during a sector or chip erase drops `busy` in the next cycle, and the erase can then be issued again.
- R11: While `busy` is 1 and `rdAddr` equals `reqAddr`, `rdSel`=2 (status). `toggleBit` starts at 0 for each operation and flips after each such read. Other addresses keep `rdSel` at 0.
- R12: At most one request is high in any cycle, and each request lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Host byte write strobe |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | 8 | Write data / opcode |
| rdEn | input | 1 | Host read strobe |
| rdAddr | input | ADDR_W | Read address |
| protectOn | input | 1 | Write protection flag from the sequence detector |
| progReq | output | 1 | One-cycle request to program a byte |
| eraseSecReq | output | 1 | One-cycle request to erase a sector |
| eraseAllReq | output | 1 | One-cycle request to erase the full array |
| reqAddr | output | ADDR_W | Target address of the current/last operation |
| reqData | output | 8 | Byte value for a program |
| busy | output | 1 | Timed operation in progress |
| rdSel | output | 2 | Read source: 0 array, 1 identification, 2 status |
| idByte | output | 8 | Identification byte for the current read address |
| toggleBit | output | 1 | Value for status bit 6 on the current read |

## Verification
Command pairs come from a table in which each row has a setup opcode, an execute byte and a protection state. The rows cover the three matched pairs, cross-mismatched execute bytes, FFh cancels and protected attempts. A matched pair must give exactly one request of the correct kind, address and busy length. Every other row must give none, and a follow-up write shows that the sequence really returned to idle. Directed sequences then separate two cases: FFh during a program has no effect, while FFh during an erase cuts it short. Further sequences check that writes during busy cannot arm a new command, that `toggleBit` alternates only on reads of the target address, and that identification codes depend on the address.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [1:0] {OP_NONE, OP_PROG, OP_SEC, OP_ALL} op_e;
  typedef enum logic [1:0] {RD_ARRAY = 2'd0, RD_ID = 2'd1, RD_STATUS = 2'd2} rdsel_e;

  // strobes from control to datapath
  typedef struct packed {
    op_e  fireOp;
    logic abortRun;
    logic idMode;
  } ctl_s;

  localparam logic [7:0] CMD_PROG   = 8'h10;
  localparam logic [7:0] CMD_SEC    = 8'h20;
  localparam logic [7:0] CMD_SEC_GO = 8'hD0;
  localparam logic [7:0] CMD_ALL    = 8'h30;
  localparam logic [7:0] CMD_ABORT  = 8'hFF;
  localparam logic [7:0] CMD_ID     = 8'h90;
  localparam logic [7:0] ID_MFR     = 8'hBF;
  localparam logic [7:0] ID_DEV     = 8'h04;
endpackage

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic       protectOn,
  input  logic       busy,
  input  logic       runErase,
  output ctl_s       ctl
);
  typedef enum logic [1:0] {S_IDLE, S_PROG, S_SEC, S_ALL} state_e;

  state_e state, nextState;
  logic   idMode, nextId;
  op_e    fireOp;
  logic   abortRun;

  always_comb begin
    nextState = state;
    nextId    = idMode;
    fireOp    = OP_NONE;
    abortRun  = 1'b0;
    if (wrEn) begin
      if (busy) begin
        if (wrData == CMD_ABORT && runErase) abortRun = 1'b1;
      end else begin
        unique case (state)
          S_IDLE: begin
            unique case (wrData)
              CMD_PROG: begin nextId = 1'b0; if (!protectOn) nextState = S_PROG; end
              CMD_SEC:  begin nextId = 1'b0; if (!protectOn) nextState = S_SEC;  end
              CMD_ALL:  begin nextId = 1'b0; if (!protectOn) nextState = S_ALL;  end
              CMD_ABORT: nextId = 1'b0;
              CMD_ID:    nextId = 1'b1;
              default: ;
            endcase
          end
          S_PROG: begin
            nextState = S_IDLE;
            if (wrData != CMD_ABORT && !protectOn) fireOp = OP_PROG;
          end
          S_SEC: begin
            nextState = S_IDLE;
            if (wrData == CMD_SEC_GO && !protectOn) fireOp = OP_SEC;
          end
          S_ALL: begin
            nextState = S_IDLE;
            if (wrData == CMD_ALL && !protectOn) fireOp = OP_ALL;
          end
          default: nextState = S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      idMode <= 1'b0;
    end else begin
      state  <= nextState;
      idMode <= nextId;
    end
  end

  assign ctl.fireOp   = fireOp;
  assign ctl.abortRun = abortRun;
  assign ctl.idMode   = idMode;
endmodule

// File: rtl/flash_cmd_dp.sv
module flash_cmd_dp
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int SECT_BITS = 8,
  parameter int PROG_CYC  = 1750,
  parameter int SEC_CYC   = 200000,
  parameter int ALL_CYC   = 1000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_s              ctl,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic              busy,
  output logic              runErase,
  output logic              progReq,
  output logic              eraseSecReq,
  output logic              eraseAllReq,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [7:0]        reqData,
  output logic [1:0]        rdSel,
  output logic [7:0]        idByte,
  output logic              toggleBit
);
  localparam int MAX_A   = (PROG_CYC > SEC_CYC) ? PROG_CYC : SEC_CYC;
  localparam int MAX_CYC = (MAX_A > ALL_CYC) ? MAX_A : ALL_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0]  cnt, loadVal;
  logic [ADDR_W-1:0] tgtAddr;
  logic              rdHit;

  always_comb begin
    tgtAddr = wrAddr;
    loadVal = CNT_W'(PROG_CYC - 1);
    unique case (ctl.fireOp)
      OP_SEC: begin
        tgtAddr = {wrAddr[ADDR_W-1:SECT_BITS], {SECT_BITS{1'b0}}};
        loadVal = CNT_W'(SEC_CYC - 1);
      end
      OP_ALL:  loadVal = CNT_W'(ALL_CYC - 1);
      default: ;
    endcase
  end

  assign rdHit = busy && (rdAddr == reqAddr);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy        <= 1'b0;
      runErase    <= 1'b0;
      cnt         <= '0;
      progReq     <= 1'b0;
      eraseSecReq <= 1'b0;
      eraseAllReq <= 1'b0;
      reqAddr     <= '0;
      reqData     <= '0;
      toggleBit   <= 1'b0;
    end else begin
      progReq     <= (ctl.fireOp == OP_PROG);
      eraseSecReq <= (ctl.fireOp == OP_SEC);
      eraseAllReq <= (ctl.fireOp == OP_ALL);
      if (ctl.fireOp != OP_NONE) begin
        busy      <= 1'b1;
        runErase  <= (ctl.fireOp != OP_PROG);
        cnt       <= loadVal;
        reqAddr   <= tgtAddr;
        reqData   <= wrData;
        toggleBit <= 1'b0;
      end else if (busy) begin
        if (ctl.abortRun || cnt == '0) begin
          busy     <= 1'b0;
          runErase <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
        end
        if (rdEn && rdHit) toggleBit <= ~toggleBit;
      end
    end
  end

  always_comb begin
    if (rdHit)           rdSel = RD_STATUS;
    else if (ctl.idMode) rdSel = RD_ID;
    else                 rdSel = RD_ARRAY;
    idByte = 8'h00;
    if (ctl.idMode) begin
      if (rdAddr == '0)               idByte = ID_MFR;
      else if (rdAddr == ADDR_W'(1))  idByte = ID_DEV;
    end
  end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int SECT_BITS = 8,
  parameter int PROG_CYC  = 1750,
  parameter int SEC_CYC   = 200000,
  parameter int ALL_CYC   = 1000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              protectOn,
  output logic              progReq,
  output logic              eraseSecReq,
  output logic              eraseAllReq,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [7:0]        reqData,
  output logic              busy,
  output logic [1:0]        rdSel,
  output logic [7:0]        idByte,
  output logic              toggleBit
);
  ctl_s ctl;
  logic runErase;

  flash_cmd_fsm u_fsm (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .protectOn(protectOn), .busy(busy), .runErase(runErase), .ctl(ctl)
  );

  flash_cmd_dp #(
    .ADDR_W(ADDR_W), .SECT_BITS(SECT_BITS),
    .PROG_CYC(PROG_CYC), .SEC_CYC(SEC_CYC), .ALL_CYC(ALL_CYC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .busy(busy), .runErase(runErase),
    .progReq(progReq), .eraseSecReq(eraseSecReq), .eraseAllReq(eraseAllReq),
    .reqAddr(reqAddr), .reqData(reqData), .rdSel(rdSel), .idByte(idByte),
    .toggleBit(toggleBit)
  );
endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk #(
  parameter int ADDR_W    = 19,
  parameter int SECT_BITS = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              protectOn,
  input logic              progReq,
  input logic              eraseSecReq,
  input logic              eraseAllReq,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              busy,
  input logic [1:0]        rdSel
);
  logic anyReq;
  assign anyReq = progReq | eraseSecReq | eraseAllReq;

  assert_req_onehot_R12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({progReq, eraseSecReq, eraseAllReq}));

  assert_req_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    anyReq |=> !anyReq);

  assert_req_starts_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    anyReq |-> $rose(busy));

  assert_sector_aligned_R3: assert property (@(posedge clk) disable iff (!rstN)
    eraseSecReq |-> (reqAddr[SECT_BITS-1:0] == '0));

  assert_no_req_protected_R7: assert property (@(posedge clk) disable iff (!rstN)
    anyReq |-> !$past(protectOn));

  assert_status_only_busy_R11: assert property (@(posedge clk) disable iff (!rstN)
    (rdSel == 2'd2) |-> busy);
endmodule

bind flash_cmd_ctrl flash_cmd_chk #(.ADDR_W(ADDR_W), .SECT_BITS(SECT_BITS)) u_chk (.*);

// File: tb/flash_cmd_ctrl_tb.sv
module flash_cmd_ctrl_tb;
  localparam int AW = 19;
  localparam int PC = 5;
  localparam int SC = 9;
  localparam int AC = 13;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [7:0]    wrData = '0;
  logic          rdEn = 1'b0;
  logic [AW-1:0] rdAddr = '0;
  logic          protectOn = 1'b0;
  logic          progReq, eraseSecReq, eraseAllReq, busy, toggleBit;
  logic [AW-1:0] reqAddr;
  logic [7:0]    reqData, idByte;
  logic [1:0]    rdSel;

  flash_cmd_ctrl #(.ADDR_W(AW), .SECT_BITS(8), .PROG_CYC(PC), .SEC_CYC(SC), .ALL_CYC(AC)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .protectOn(protectOn),
    .progReq(progReq), .eraseSecReq(eraseSecReq), .eraseAllReq(eraseAllReq),
    .reqAddr(reqAddr), .reqData(reqData), .busy(busy), .rdSel(rdSel),
    .idByte(idByte), .toggleBit(toggleBit)
  );

  always #2 clk = ~clk;

  int total = 0;
  int bad = 0;
  int busyCnt = 0;
  int gotOp;
  logic [AW-1:0] gotAddr;
  logic [7:0] gotData;
  logic gotBusy;
  logic [1:0] gotSel;
  logic [7:0] gotId;
  logic gotTog;

  always @(negedge clk) if (busy) busyCnt++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // op code seen: 0 none, 1 program, 2 sector, 3 chip
  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    gotOp = progReq ? 1 : eraseSecReq ? 2 : eraseAllReq ? 3 : 0;
    gotAddr = reqAddr; gotData = reqData; gotBusy = busy;
  endtask

  task automatic rd(input logic [AW-1:0] a);
    @(negedge clk);
    rdEn = 1'b1; rdAddr = a;
    #1;
    gotSel = rdSel; gotId = idByte; gotTog = toggleBit;
    @(posedge clk);
    #1 rdEn = 1'b0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  typedef struct packed {
    logic [7:0]    setup;
    logic [AW-1:0] addr;
    logic [7:0]    data;
    logic          prot;
    logic [1:0]    expOp;
    logic [AW-1:0] expAddr;
    logic [7:0]    expCyc;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{8'h10, 19'h12345, 8'hA5, 1'b0, 2'd1, 19'h12345, 8'(PC)},  // R2
    '{8'h10, 19'h7FFFF, 8'h00, 1'b0, 2'd1, 19'h7FFFF, 8'(PC)},  // R2
    '{8'h20, 19'h3ABCD, 8'hD0, 1'b0, 2'd2, 19'h3AB00, 8'(SC)},  // R3
    '{8'h30, 19'h00000, 8'h30, 1'b0, 2'd3, 19'h00000, 8'(AC)},  // R4
    '{8'h10, 19'h00042, 8'hFF, 1'b0, 2'd0, 19'h00000, 8'd0},    // R5
    '{8'h20, 19'h00042, 8'hFF, 1'b0, 2'd0, 19'h00000, 8'd0},    // R5
    '{8'h20, 19'h00100, 8'h30, 1'b0, 2'd0, 19'h00000, 8'd0},    // R6
    '{8'h30, 19'h00100, 8'hD0, 1'b0, 2'd0, 19'h00000, 8'd0},    // R6
    '{8'h20, 19'h05500, 8'hD0, 1'b1, 2'd0, 19'h00000, 8'd0},    // R7
    '{8'h10, 19'h05500, 8'h66, 1'b1, 2'd0, 19'h00000, 8'd0}     // R7
  };

  initial begin
    #(4 * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0, "R1 busy", busy, 0);
    chk({progReq, eraseSecReq, eraseAllReq} == 3'b0, "R1 requests", {progReq, eraseSecReq, eraseAllReq}, 0);
    chk(rdSel == 2'd0, "R1 rdSel", rdSel, 0);
    chk(toggleBit == 0, "R1 toggleBit", toggleBit, 0);

    // table of command pairs
    for (int i = 0; i < NV; i++) begin
      protectOn = VECS[i].prot;
      wr(19'h0, VECS[i].setup);
      busyCnt = 0;
      wr(VECS[i].addr, VECS[i].data);
      chk(gotOp == int'(VECS[i].expOp), "R2/R3/R4/R6/R7 request kind", gotOp, VECS[i].expOp);
      if (VECS[i].expOp != 2'd0) begin
        chk(gotAddr == VECS[i].expAddr, "R2/R3 reqAddr", gotAddr, VECS[i].expAddr);
        if (VECS[i].expOp == 2'd1) chk(gotData == VECS[i].data, "R2 reqData", gotData, VECS[i].data);
        @(negedge clk);
        chk({progReq, eraseSecReq, eraseAllReq} == 3'b0, "R12 single pulse", {progReq, eraseSecReq, eraseAllReq}, 0);
        waitIdle();
        chk(busyCnt == int'(VECS[i].expCyc), "R2/R3/R4 busy length", busyCnt, VECS[i].expCyc);
      end else begin
        chk(gotBusy == 0, "R5/R6/R7 no busy", gotBusy, 0);
        // a plain data write must now do nothing (sequence back at idle)
        wr(VECS[i].addr, 8'h55);
        chk(gotOp == 0 && busy == 0, "R5 back to idle", gotOp, 0);
      end
    end
    protectOn = 1'b0;

    // R8 identification, entered while protected
    protectOn = 1'b1;
    wr(19'h0, 8'h90);
    rd(19'h0);
    chk(gotSel == 2'd1 && gotId == 8'hBF, "R8 id addr0", {gotSel, gotId}, {2'd1, 8'hBF});
    rd(19'h1);
    chk(gotId == 8'h04, "R8 id addr1", gotId, 8'h04);
    rd(19'h5);
    chk(gotId == 8'h00, "R8 id other", gotId, 0);
    wr(19'h0, 8'hFF);
    rd(19'h0);
    chk(gotSel == 2'd0, "R8 exit by FF", gotSel, 0);
    wr(19'h0, 8'h90);
    wr(19'h0, 8'h20);
    rd(19'h0);
    chk(gotSel == 2'd0, "R8 exit by setup", gotSel, 0);
    protectOn = 1'b0;

    // R11 status reads during sector erase
    wr(19'h0, 8'h20);
    wr(19'h01234, 8'hD0);
    rd(19'h01200);
    chk(gotSel == 2'd2 && gotTog == 0, "R11 first status read", {gotSel, gotTog}, {2'd2, 1'b0});
    rd(19'h01200);
    chk(gotTog == 1, "R11 toggle flips", gotTog, 1);
    rd(19'h00777);
    chk(gotSel == 2'd0, "R11 other address", gotSel, 0);
    rd(19'h01200);
    chk(gotTog == 0, "R11 toggle held on other read", gotTog, 0);
    waitIdle();
    rd(19'h01200);
    chk(gotSel == 2'd0, "R11 status ends", gotSel, 0);

    // R9 writes ignored while busy, FF does not stop a program
    wr(19'h0, 8'h10);
    busyCnt = 0;
    wr(19'h00ABC, 8'h12);
    wr(19'h0, 8'hFF);
    wr(19'h0, 8'h10);
    waitIdle();
    chk(busyCnt == PC, "R9 program not aborted", busyCnt, PC);
    wr(19'h00ABC, 8'h77);
    chk(gotOp == 0, "R9 setup during busy ignored", gotOp, 0);

    // R10 abort sector erase and reissue
    wr(19'h0, 8'h20);
    busyCnt = 0;
    wr(19'h04400, 8'hD0);
    wr(19'h0, 8'hFF);
    chk(gotBusy == 0, "R10 erase aborted", gotBusy, 0);
    chk(busyCnt == 2, "R10 abort timing", busyCnt, 2);
    wr(19'h0, 8'h20);
    busyCnt = 0;
    wr(19'h04400, 8'hD0);
    chk(gotOp == 2, "R10 reissue", gotOp, 2);
    waitIdle();
    chk(busyCnt == SC, "R10 reissue length", busyCnt, SC);

    // R10 abort chip erase
    wr(19'h0, 8'h30);
    wr(19'h0, 8'h30);
    wr(19'h0, 8'hFF);
    chk(gotBusy == 0, "R10 chip erase aborted", gotBusy, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule